// File: doc/BRIEF.md
# Picture Memory Nametable Mirroring Mapper

This block sits between a picture processor and its video memory. Every request carries an address, a direction and a 3-bit mirroring mode. The block first folds the address into a 14-bit space. Requests in the lower 8 KiB (the pattern region) are passed to an external cartridge port. Requests in the nametable region are served by four internal 1 KiB screen RAMs. The mirroring mode, sampled with each request, picks which RAM serves it.

The top of the space, 0x3000 to 0x3FFF, is an alias of 0x2000 to 0x2FFF. Every accepted request, in either region, shows its folded address on a notify output so that cartridge logic can watch the address lines.

A phase machine accepts one request per clock, with no stall. In the cycle after acceptance it presents the response phase of that request. The phases are:

- `ST_IDLE`: no request was accepted.
- `ST_CART_RD`: cartridge read.
- `ST_CART_WR`: cartridge write.
- `ST_NT_RD`: screen RAM read.
- `ST_NT_WR`: screen RAM write.
- `ST_WR_REJ`: nametable write refused because the mode code is not recognised.

Each phase is entered from any phase:

- `ST_IDLE`, when `req_valid` is low.
- `ST_CART_RD` or `ST_CART_WR`, for a pattern-region request, chosen by `req_write`.
- `ST_NT_RD`, for a nametable read in any mode.
- `ST_NT_WR`, for a nametable write with a known mode.
- `ST_WR_REJ`, for a nametable write with mode 5, 6 or 7.

Every phase lasts exactly one cycle.

Top module: `vram_mirror_map`

## Requirements
- R1: Only bits 13:0 of `req_addr` are used. Bits above 13 have no effect on routing, data or `notify_addr`.
- R2: A request whose folded address is below 0x2000 drives `cart_req` high in the next cycle, with `cart_we` equal to the request direction, `cart_addr` equal to folded bits 12:0 and `cart_wdata` equal to the write data. For a read, `rsp_rdata` in that cycle equals `cart_rdata`.
- R3: A masked address from 0x3000 to 0x3FFF is reduced by 0x1000 before decoding. It then reaches the same screen RAM byte as its 0x2000-region twin.
- R4: One cycle after each accepted request, `notify_valid` is high and `notify_addr` holds the folded 14-bit address. This holds for both regions and both directions.
- R5: Mode code 0 selects the screen RAM by folded bit 10.
- R6: Mode code 1 selects the screen RAM by folded bit 11.
- R7: Mode code 2 sends every nametable access to RAM 0. Mode code 3 sends every nametable access to RAM 1.
- R8: Mode code 4 selects the RAM by folded bits 11:10. In all modes the byte offset within a RAM is folded bits 9:0.
- R9: A nametable read with mode code 5, 6 or 7 is decoded as mode 4.
- R10: A nametable write with mode code 5, 6 or 7 changes no RAM byte. `wr_err` is high for the one cycle after that request, and `wr_err` is low otherwise.
- R11: `rsp_valid` is high exactly in the cycle after each read request. Requests may come on every cycle. With no request, `rsp_valid`, `notify_valid`, `cart_req` and `wr_err` are low.
- R12: During and right after reset, `rsp_valid`, `notify_valid`, `cart_req`, `cart_we` and `wr_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| req_valid | input | 1 | request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (16) | raw picture memory address |
| req_wdata | input | DATA_W (8) | write data |
| req_mode | input | 3 | mirroring mode code (0 vert, 1 horiz, 2 single lower, 3 single upper, 4 four-screen) |
| rsp_valid | output | 1 | read data valid |
| rsp_rdata | output | DATA_W (8) | read data |
| wr_err | output | 1 | refused nametable write |
| notify_valid | output | 1 | folded address valid on notify_addr |
| notify_addr | output | 14 | folded address for the cartridge side |
| cart_req | output | 1 | cartridge access strobe |
| cart_we | output | 1 | cartridge write enable |
| cart_addr | output | 13 | cartridge pattern address |
| cart_wdata | output | DATA_W (8) | cartridge write data |
| cart_rdata | input | DATA_W (8) | cartridge read data, returned in the same cycle |

## Verification
Two events can fall in the same cycle:

- the response phase of one request (read data, notify, cartridge strobe or refusal flag);
- the decode and RAM write of the following request.

The bench provokes this overlap by issuing requests back to back on every cycle. Addresses, modes and directions are random, so a write is often followed at once by a read of the same byte through another alias or another mode. Each response is judged one cycle after its request against a byte-level model of the four RAMs. The model is updated in request order, so the check also confirms that read data reflect a write accepted on the cycle before.

// File: rtl/vmm_pkg.sv
package vmm_pkg;
    localparam int VA_W      = 14;
    localparam int BANK_W    = 2;
    localparam int NUM_BANKS = 1 << BANK_W;

    localparam logic [2:0] MODE_VERT   = 3'd0;
    localparam logic [2:0] MODE_HORZ   = 3'd1;
    localparam logic [2:0] MODE_ONE_LO = 3'd2;
    localparam logic [2:0] MODE_ONE_HI = 3'd3;
    localparam logic [2:0] MODE_QUAD   = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CART_RD,
        ST_CART_WR,
        ST_NT_RD,
        ST_NT_WR,
        ST_WR_REJ
    } phase_e;
endpackage

// File: rtl/vmm_addr_fold.sv
module vmm_addr_fold
    import vmm_pkg::*;
#(
    parameter int IN_W = 16
) (
    input  logic [IN_W-1:0] addr_in,
    output logic [VA_W-1:0] addr_out,
    output logic            is_cart
);
    localparam logic [VA_W-1:0] UPPER_BASE = 14'h3000;
    localparam logic [VA_W-1:0] ALIAS_STEP = 14'h1000;

    logic [VA_W-1:0] masked;

    always_comb begin
        masked   = addr_in[VA_W-1:0];
        addr_out = (masked >= UPPER_BASE) ? (masked - ALIAS_STEP) : masked;
        is_cart  = ~addr_out[VA_W-1];
    end

    // the folded address never lands in the aliased top region (R3)
    always_comb begin
        p_fold_below_top_r3: assert (addr_out < UPPER_BASE);
    end
endmodule

// File: rtl/vmm_bank_sel.sv
module vmm_bank_sel
    import vmm_pkg::*;
#(
    parameter int OFS_W = 10
) (
    input  logic [2:0]        mode,
    input  logic [VA_W-1:0]   addr,
    output logic [BANK_W-1:0] bank,
    output logic              mode_ok
);
    localparam int LO_BIT = OFS_W;
    localparam int HI_BIT = OFS_W + 1;

    always_comb begin
        mode_ok = 1'b1;
        case (mode)
            MODE_VERT:   bank = {1'b0, addr[LO_BIT]};
            MODE_HORZ:   bank = {1'b0, addr[HI_BIT]};
            MODE_ONE_LO: bank = 2'd0;
            MODE_ONE_HI: bank = 2'd1;
            MODE_QUAD:   bank = addr[HI_BIT:LO_BIT];
            default: begin
                bank    = addr[HI_BIT:LO_BIT];
                mode_ok = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/vmm_screen_ram.sv
module vmm_screen_ram #(
    parameter int OFS_W  = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << OFS_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[ofs] <= wdata;
            end else begin
                rdata <= mem[ofs];
            end
        end
    end
endmodule

// File: rtl/vram_mirror_map.sv
module vram_mirror_map
    import vmm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int OFS_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [2:0]        req_mode,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              wr_err,
    output logic              notify_valid,
    output logic [VA_W-1:0]   notify_addr,
    output logic              cart_req,
    output logic              cart_we,
    output logic [VA_W-2:0]   cart_addr,
    output logic [DATA_W-1:0] cart_wdata,
    input  logic [DATA_W-1:0] cart_rdata
);
    logic [VA_W-1:0]   fold_addr;
    logic              fold_cart;
    logic [BANK_W-1:0] sel_bank;
    logic              sel_ok;

    phase_e            state, state_nxt;
    logic [VA_W-1:0]   lat_addr;
    logic [DATA_W-1:0] lat_wdata;
    logic [BANK_W-1:0] lat_bank;

    logic [NUM_BANKS-1:0] bank_en;
    logic [DATA_W-1:0]    bank_rdata [NUM_BANKS];

    vmm_addr_fold #(.IN_W(ADDR_W)) u_fold (
        .addr_in (req_addr),
        .addr_out(fold_addr),
        .is_cart (fold_cart)
    );

    vmm_bank_sel #(.OFS_W(OFS_W)) u_sel (
        .mode   (req_mode),
        .addr   (fold_addr),
        .bank   (sel_bank),
        .mode_ok(sel_ok)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            assign bank_en[b] = req_valid && !fold_cart
                                && (sel_bank == BANK_W'(b))
                                && (!req_write || sel_ok);
            vmm_screen_ram #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_ram (
                .clk  (clk),
                .en   (bank_en[b]),
                .we   (req_write),
                .ofs  (fold_addr[OFS_W-1:0]),
                .wdata(req_wdata),
                .rdata(bank_rdata[b])
            );
        end
    endgenerate

    // next phase from the incoming request
    always_comb begin
        if (!req_valid) begin
            state_nxt = ST_IDLE;
        end else if (fold_cart) begin
            state_nxt = req_write ? ST_CART_WR : ST_CART_RD;
        end else if (!req_write) begin
            state_nxt = ST_NT_RD;
        end else begin
            state_nxt = sel_ok ? ST_NT_WR : ST_WR_REJ;
        end
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_bank  <= '0;
        end else begin
            state <= state_nxt;
            if (req_valid) begin
                lat_addr  <= fold_addr;
                lat_wdata <= req_wdata;
                lat_bank  <= sel_bank;
            end
        end
    end

    // outputs from the current phase
    always_comb begin
        rsp_valid    = 1'b0;
        rsp_rdata    = '0;
        wr_err       = 1'b0;
        notify_valid = 1'b1;
        cart_req     = 1'b0;
        cart_we      = 1'b0;
        notify_addr  = lat_addr;
        cart_addr    = lat_addr[VA_W-2:0];
        cart_wdata   = lat_wdata;
        unique case (state)
            ST_IDLE:    notify_valid = 1'b0;
            ST_CART_RD: begin
                cart_req  = 1'b1;
                rsp_valid = 1'b1;
                rsp_rdata = cart_rdata;
            end
            ST_CART_WR: begin
                cart_req = 1'b1;
                cart_we  = 1'b1;
            end
            ST_NT_RD: begin
                rsp_valid = 1'b1;
                rsp_rdata = bank_rdata[lat_bank];
            end
            ST_NT_WR:   ;
            ST_WR_REJ:  wr_err = 1'b1;
            default:    notify_valid = 1'b0;
        endcase
    end

    // at most one screen RAM is touched per cycle (R8)
    p_one_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_en));

    // refused writes never enable a RAM (R10)
    p_no_bad_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_mode > MODE_QUAD) |-> (bank_en == '0));

    // error flag only follows a write with an unknown mode (R10)
    p_err_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(req_valid && req_write && req_mode > MODE_QUAD));

    // notify follows every request (R4)
    p_notify_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> notify_valid);

    // no notified address in the aliased top region (R3)
    p_notify_folded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        notify_valid |-> (notify_addr < 14'h3000));

    // cartridge strobe only in the pattern region (R2)
    p_cart_region_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cart_req |-> !notify_addr[VA_W-1]);

    // read response only after a read request (R11)
    p_rsp_after_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));
endmodule

// File: tb/tb_vram_mirror_map.sv
`timescale 1ns/1ps
module tb_vram_mirror_map;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [2:0]  req_mode = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic        wr_err;
    logic        notify_valid;
    logic [13:0] notify_addr;
    logic        cart_req;
    logic        cart_we;
    logic [12:0] cart_addr;
    logic [7:0]  cart_wdata;
    logic [7:0]  cart_rdata;

    int errors = 0;
    int checks = 0;
    logic [7:0] mdl [4096];

    always #2.5 clk = ~clk;

    function automatic logic [7:0] cart_fn(logic [12:0] a);
        return a[7:0] ^ {3'b0, a[12:8]} ^ 8'h5A;
    endfunction

    assign cart_rdata = cart_fn(cart_addr);

    vram_mirror_map dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mode(req_mode),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .wr_err(wr_err),
        .notify_valid(notify_valid), .notify_addr(notify_addr),
        .cart_req(cart_req), .cart_we(cart_we), .cart_addr(cart_addr),
        .cart_wdata(cart_wdata), .cart_rdata(cart_rdata)
    );

    function automatic logic [13:0] fold(logic [15:0] a);
        logic [13:0] m = a[13:0];
        return (m >= 14'h3000) ? m - 14'h1000 : m;
    endfunction

    function automatic logic [1:0] bank_of(logic [2:0] m, logic [13:0] f);
        case (m)
            3'd0:    return {1'b0, f[10]};
            3'd1:    return {1'b0, f[11]};
            3'd2:    return 2'd0;
            3'd3:    return 2'd1;
            default: return f[11:10];
        endcase
    endfunction

    function automatic string mode_tag(logic [2:0] m);
        case (m)
            3'd0:       return "R5";
            3'd1:       return "R6";
            3'd2, 3'd3: return "R7";
            3'd4:       return "R8";
            default:    return "R9";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    // drive one request at a falling edge, judge its response one cycle later
    task automatic op(input bit w, input logic [15:0] a, input logic [7:0] d, input logic [2:0] m);
        logic [13:0] f;
        logic [11:0] idx;
        string ntag;
        f = fold(a);
        idx = {bank_of(m, f), f[9:0]};
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_mode = m;
        @(negedge clk);
        ntag = (a[13:12] == 2'b11) ? "R3" : ((a[15:14] != 2'b00) ? "R1" : "R4");
        chk(notify_valid == 1'b1 && notify_addr == f, ntag, int'(notify_addr), int'(f));
        if (f < 14'h2000) begin
            chk(cart_req == 1'b1 && cart_we == w && cart_addr == f[12:0], "R2",
                int'({cart_req, cart_we, cart_addr}), int'({1'b1, w, f[12:0]}));
            chk(wr_err == 1'b0, "R10", int'(wr_err), 0);
            if (w) begin
                chk(cart_wdata == d && rsp_valid == 1'b0, "R2", int'(cart_wdata), int'(d));
            end else begin
                chk(rsp_valid == 1'b1 && rsp_rdata == cart_fn(f[12:0]), "R2",
                    int'(rsp_rdata), int'(cart_fn(f[12:0])));
            end
        end else if (w) begin
            chk(rsp_valid == 1'b0 && cart_req == 1'b0, "R11",
                int'({rsp_valid, cart_req}), 0);
            chk(wr_err == (m > 3'd4), "R10", int'(wr_err), int'(m > 3'd4));
            if (m <= 3'd4) mdl[idx] = d;
        end else begin
            chk(cart_req == 1'b0 && wr_err == 1'b0, "R11", int'({cart_req, wr_err}), 0);
            chk(rsp_valid == 1'b1 && rsp_rdata == mdl[idx], mode_tag(m),
                int'(rsp_rdata), int'(mdl[idx]));
        end
    endtask

    task automatic idle_check();
        req_valid = 1'b0;
        @(negedge clk);
        chk(!rsp_valid && !notify_valid && !cart_req && !wr_err, "R11",
            int'({rsp_valid, notify_valid, cart_req, wr_err}), 0);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R11 watchdog expired act=0x0 exp=0x1");
        finish_run();
    end

    initial begin
        void'($urandom(32'h1BADF00D));
        repeat (3) @(negedge clk);
        chk(!rsp_valid && !notify_valid && !cart_req && !cart_we && !wr_err, "R12",
            int'({rsp_valid, notify_valid, cart_req, cart_we, wr_err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rsp_valid && !notify_valid && !cart_req && !cart_we && !wr_err, "R12",
            int'({rsp_valid, notify_valid, cart_req, cart_we, wr_err}), 0);

        // fill every screen RAM byte through four-screen decoding (R8)
        for (int i = 0; i < 4096; i++) begin
            op(1'b1, 16'h2000 + 16'(i), 8'(i * 7 + 3), 3'd4);
        end
        idle_check();

        // directed corner cases
        op(1'b0, 16'h2400, 8'h00, 3'd0);   // R5: bit 10 -> bank 1
        op(1'b0, 16'h2800, 8'h00, 3'd0);   // R5: bank 0
        op(1'b0, 16'h2800, 8'h00, 3'd1);   // R6: bit 11 -> bank 1
        op(1'b0, 16'h2FFF, 8'h00, 3'd2);   // R7: bank 0
        op(1'b0, 16'h2C11, 8'h00, 3'd3);   // R7: bank 1
        op(1'b0, 16'h2C00, 8'h00, 3'd7);   // R9: falls back to bank 3
        op(1'b1, 16'h3123, 8'hA5, 3'd4);   // R3: alias write
        op(1'b0, 16'h2123, 8'h00, 3'd4);   // R3: twin reads it
        op(1'b1, 16'h2005, 8'h3C, 3'd6);   // R10: refused
        op(1'b0, 16'h2005, 8'h00, 3'd4);   // R10: byte unchanged
        op(1'b0, 16'hC805, 8'h00, 3'd4);   // R1: upper bits ignored
        op(1'b1, 16'h1ABC, 8'h77, 3'd5);   // R2: cartridge write
        op(1'b0, 16'h0042, 8'h00, 3'd1);   // R2: cartridge read
        idle_check();

        // random back-to-back traffic
        for (int n = 0; n < 3000; n++) begin
            op(1'($urandom), 16'($urandom), 8'($urandom), 3'($urandom));
            if (($urandom % 16) == 0) idle_check();
        end
        idle_check();
        finish_run();
    end
endmodule